// File: doc/BRIEF.md
# Set/Clear/Toggle Control Register Bank

This block holds a small bank of memory-mapped control registers behind a single-cycle bus made of an address, a write strobe, write data and read data. Each register's current value drives downstream logic through a flat output vector. Software can overwrite a register outright. It can also change chosen bits without a read-modify-write sequence, through three alias addresses that OR, AND-NOT or XOR the write data into the stored value.

Parameters configure each register separately. One bit selects whether the register answers its alias addresses. One bit selects a byte-wide or a 32-bit register. A protection mask names bits that a plain overwrite may not change; only the set and clear aliases can move those bits. Each register also has its own reset value. Every register owns a 16-byte window of four 32-bit slots, whatever its width.

Top module: `scr_bank`

## Requirements
- R1: While rst_ni is low, every register holds its parameterized reset value, and the value is visible on regs_o and through reads.
- R2: A write to slot offset 0x0 loads every unprotected bit of the register from the write data.
- R3: Bits set in a register's protection mask keep their value on a write to offset 0x0. The set alias (0x4) and the clear alias (0x8) can still change them.
- R4: A write to offset 0x4 sets every bit whose write-data bit is 1 and leaves all other bits unchanged.
- R5: A write to offset 0x8 clears every bit whose write-data bit is 1 and leaves all other bits unchanged.
- R6: A write to offset 0xC inverts every unprotected bit whose write-data bit is 1. Protected bits and bits with write-data 0 are unchanged.
- R7: For a register configured without aliases, writes to offsets 0x4, 0x8 and 0xC leave the register unchanged.
- R8: The register index is addr_i[ADDR_W-1:4] and the access slot is addr_i[3:2], with 0=value, 1=set, 2=clear and 3=toggle. addr_i[1:0] is ignored.
- R9: A read from any of the four slots of a mapped register returns its value. A read from an unmapped window returns zero, and a write to an unmapped window changes no register.
- R10: A byte-wide register uses only wdata_i[7:0]. Its bits [31:8] read back as zero and show as zero on regs_o.
- R11: A write changes the register at the rising clk_i edge on which we_i is sampled high. Read data is combinational from addr_i. With we_i low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| regs_o | output | 32*N_REGS | All register values, register i at bits [32*i+31:32*i] |

## Verification
The hardest case to reach is a protected bit moving in the correct direction. It takes a set or clear alias write, followed by a plain write that must leave the bit alone and a toggle that must also skip it. The stimulus does this on purpose. It first sets the protected byte of the 32-bit register, then overwrites the register with zero. It then clears part of the protected byte and toggles all bits, and the reference model is compared after each step. A run of random writes then mixes all four slots across every register, including the ones without aliases and the byte-wide ones.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [1:0] {
    ACC_VAL = 2'd0,
    ACC_SET = 2'd1,
    ACC_CLR = 2'd2,
    ACC_TOG = 2'd3
  } acc_e;
  localparam int WIN_BITS = 4;
  localparam int DATA_W   = 32;
endpackage

// File: rtl/scr_decode.sv
module scr_decode
  import scr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_REGS = 4,
  localparam int IDX_W = ADDR_W - WIN_BITS
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output acc_e              acc_o
);
  logic unused_lo;
  assign unused_lo = ^addr_i[1:0];
  assign idx_o = addr_i[ADDR_W-1:WIN_BITS];
  assign acc_o = acc_e'(addr_i[3:2]);
  assign hit_o = (int'(idx_o) < N_REGS);
endmodule

// File: rtl/scr_reg.sv
module scr_reg
  import scr_pkg::*;
#(
  parameter bit          HAS_ALIAS = 1'b1,
  parameter bit          IS_BYTE   = 1'b0,
  parameter logic [31:0] PROT      = '0,
  parameter logic [31:0] RST       = '0,
  localparam int W = IS_BYTE ? 8 : DATA_W
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  acc_e        acc_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);
  logic [W-1:0] q, nxt, wd;
  localparam logic [W-1:0] PM = PROT[W-1:0];

  assign wd = wdata_i[W-1:0];

  generate
    if (W < DATA_W) begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^wdata_i[DATA_W-1:W];
    end
  endgenerate

  always_comb begin
    nxt = q;
    if (wr_i) begin
      unique case (acc_i)
        ACC_VAL: nxt = (q & PM) | (wd & ~PM);
        ACC_SET: if (HAS_ALIAS) nxt = q | wd;
        ACC_CLR: if (HAS_ALIAS) nxt = q & ~wd;
        ACC_TOG: if (HAS_ALIAS) nxt = q ^ (wd & ~PM);
        default: nxt = q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST[W-1:0];
    else         q <= nxt;
  end

  assign q_o = DATA_W'(q);

  p_plain_prot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && acc_i == ACC_VAL) |=> ((q & PM) == ($past(q) & PM)));

  p_tog_prot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && acc_i == ACC_TOG) |=> ((q & PM) == ($past(q) & PM)));

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q));

  generate
    if (HAS_ALIAS) begin : g_alias_chk
      p_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && acc_i == ACC_SET) |=> ((q & $past(wd)) == $past(wd)));
      p_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && acc_i == ACC_CLR) |=> ((q & $past(wd)) == '0));
    end else begin : g_noalias_chk
      p_no_alias_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && acc_i != ACC_VAL) |=> $stable(q));
    end
  endgenerate
endmodule

// File: rtl/scr_rdmux.sv
module scr_rdmux #(
  parameter int N_REGS = 4,
  parameter int IDX_W  = 4
) (
  input  logic [N_REGS*32-1:0] regs_i,
  input  logic                 hit_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [31:0]          rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_REGS; i++) begin
      if (hit_i && idx_i == IDX_W'(i)) rdata_o = regs_i[i*32 +: 32];
    end
  end
endmodule

// File: rtl/scr_bank.sv
module scr_bank
  import scr_pkg::*;
#(
  parameter int                    ADDR_W    = 8,
  parameter int                    N_REGS    = 4,
  parameter logic [N_REGS-1:0]     HAS_ALIAS = 4'b0101,
  parameter logic [N_REGS-1:0]     IS_BYTE   = 4'b1100,
  parameter logic [N_REGS*32-1:0]  PROT_MASK = {32'h0, 32'h80, 32'h0, 32'hFF00_0000},
  parameter logic [N_REGS*32-1:0]  RST_VAL   = {32'h3C, 32'h0F, 32'h1234_5678, 32'hA5},
  localparam int IDX_W = ADDR_W - WIN_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic [N_REGS*32-1:0] regs_o
);
  logic             hit;
  logic [IDX_W-1:0] idx;
  acc_e             acc;

  scr_decode #(.ADDR_W(ADDR_W), .N_REGS(N_REGS)) u_dec (
    .addr_i(addr_i), .hit_o(hit), .idx_o(idx), .acc_o(acc)
  );

  generate
    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
      logic wr;
      assign wr = we_i && hit && (idx == IDX_W'(i));
      scr_reg #(
        .HAS_ALIAS(HAS_ALIAS[i]),
        .IS_BYTE  (IS_BYTE[i]),
        .PROT     (PROT_MASK[i*32 +: 32]),
        .RST      (RST_VAL[i*32 +: 32])
      ) u_reg (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .acc_i(acc),
        .wdata_i(wdata_i), .q_o(regs_o[i*32 +: 32])
      );
    end
  endgenerate

  scr_rdmux #(.N_REGS(N_REGS), .IDX_W(IDX_W)) u_rd (
    .regs_i(regs_o), .hit_i(hit), .idx_i(idx), .rdata_o(rdata_o)
  );

  p_unmapped_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit) |=> $stable(regs_o));
endmodule

// File: tb/scr_bank_tb.sv
`timescale 1ns/1ps
module scr_bank_tb_top;
  localparam int N = 4;
  localparam logic [N-1:0]    ALIAS = 4'b0101;
  localparam logic [N-1:0]    BYTEW = 4'b1100;
  localparam logic [N*32-1:0] PROT  = {32'h0, 32'h80, 32'h0, 32'hFF00_0000};
  localparam logic [N*32-1:0] RSTV  = {32'h3C, 32'h0F, 32'h1234_5678, 32'hA5};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] addr = '0;
  logic we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N*32-1:0] regs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  logic [31:0] model [N];

  always #2 clk = ~clk;

  scr_bank #(.ADDR_W(8), .N_REGS(N), .HAS_ALIAS(ALIAS), .IS_BYTE(BYTEW),
             .PROT_MASK(PROT), .RST_VAL(RSTV)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .regs_o(regs)
  );

  function automatic logic [31:0] wmask(int r);
    return BYTEW[r] ? 32'h0000_00FF : 32'hFFFF_FFFF;
  endfunction

  // R8 layout: index from addr[7:4], slot from addr[3:2]
  task automatic model_apply(logic [7:0] a, logic [31:0] d);
    int r = int'(a[7:4]);
    int op = int'(a[3:2]);
    logic [31:0] m, p, dv, cur;
    if (r >= N) return;
    m = wmask(r);
    p = PROT[r*32 +: 32] & m;
    dv = d & m;
    cur = model[r];
    case (op)
      0: cur = (cur & p) | (dv & ~p);
      1: if (ALIAS[r]) cur = cur | dv;
      2: if (ALIAS[r]) cur = cur & ~dv;
      default: if (ALIAS[r]) cur = cur ^ (dv & ~p);
    endcase
    model[r] = cur & m;
  endtask

  // per-clock comparison of every register against the model (R11 timing)
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      for (int r = 0; r < N; r++) begin
        checks++;
        if (regs[r*32 +: 32] !== model[r]) begin
          errors++;
          $display("FAIL %s/R11 reg%0d actual %h expected %h", cur_req, r, regs[r*32 +: 32], model[r]);
        end
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(posedge clk);
    model_apply(a, d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s read %h actual %h expected %h", tag, a, rdata, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < N; r++) model[r] = RSTV[r*32 +: 32];
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset values
    cur_req = "R1";
    rd(8'h00, 32'hA5, "R1");
    rd(8'h10, 32'h1234_5678, "R1");
    rd(8'h20, 32'h0F, "R1");
    rd(8'h30, 32'h3C, "R1");
    // R2 plain write
    cur_req = "R2";
    wr(8'h00, 32'hDEAD_BEEF);
    rd(8'h00, 32'h00AD_BEEF, "R2");
    wr(8'h10, 32'hCAFE_F00D);
    rd(8'h10, 32'hCAFE_F00D, "R2");
    // R3 protected bits
    cur_req = "R3";
    wr(8'h04, 32'hFF00_0000);
    rd(8'h00, 32'hFFAD_BEEF, "R3");
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, 32'hFF00_0000, "R3");
    wr(8'h08, 32'h0F00_0000);
    rd(8'h00, 32'hF000_0000, "R3");
    // R4 set
    cur_req = "R4";
    wr(8'h04, 32'h0000_0011);
    rd(8'h00, 32'hF000_0011, "R4");
    wr(8'h24, 32'h0000_0081);
    rd(8'h20, 32'h0000_008F, "R4");
    // R5 clear
    cur_req = "R5";
    wr(8'h28, 32'h0000_0001);
    rd(8'h20, 32'h0000_008E, "R5");
    wr(8'h08, 32'h0000_0010);
    rd(8'h00, 32'hF000_0001, "R5");
    // R6 toggle skips protected bits
    cur_req = "R6";
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h00, 32'hF0FF_FFFE, "R6");
    wr(8'h2C, 32'h0000_00FF);
    rd(8'h20, 32'h0000_00F1, "R6");
    // R7 registers without aliases
    cur_req = "R7";
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h10, 32'hCAFE_F00D, "R7");
    wr(8'h38, 32'h0000_00FF);
    wr(8'h3C, 32'h0000_00FF);
    rd(8'h30, 32'h0000_003C, "R7");
    // R8 low address bits ignored
    cur_req = "R8";
    wr(8'h13, 32'h0BAD_CAFE);
    rd(8'h12, 32'h0BAD_CAFE, "R8");
    wr(8'h25, 32'h0000_0002);
    rd(8'h21, 32'h0000_00F3, "R8");
    // R9 reads at every slot, unmapped windows
    cur_req = "R9";
    for (int s = 0; s < 4; s++) rd(8'h00 + 8'(s*4), model[0], "R9");
    rd(8'h40, 32'h0, "R9");
    rd(8'hF8, 32'h0, "R9");
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h64, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0BAD_CAFE, "R9");
    // R10 byte register width
    cur_req = "R10";
    wr(8'h30, 32'hABCD_EF12);
    rd(8'h30, 32'h0000_0012, "R10");
    wr(8'h24, 32'hFFFF_FF00);
    rd(8'h20, 32'h0000_00F3, "R10");
    // R11 random mix, compared every clock
    cur_req = "R11";
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      a = {4'($urandom_range(0, 5)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      wr(a, $urandom);
      a = {4'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 2'b00};
      rd(a, (a[7:4] < 4'(N)) ? model[a[7:4]] : 32'h0, "R11");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule